// File: doc/BRIEF.md
# Character LCD Frequency Readout Sequencer

This block drives a character LCD module of the common 8-bit parallel type and keeps a frequency reading on its first line in the form `FREQ=dddddd` followed by `Hz`. After reset it issues the controller start-up commands, pacing each write with an enable pulse and a settling gap. It then waits for a reading.

A reading arrives as six packed BCD digits together with a one-cycle strobe. The strobe captures all six digits at once. The block then moves the cursor back to the start of the line and rewrites the whole string one character at a time. Each digit is chosen in turn, most significant first, and turned into its ASCII code on the way to the bus.

The data bus leaves the block through a drive-enable output that controls an external tri-state buffer. The bus is driven only while a write is in progress. At all other times the data pins read as zero.

Top module: `lcd_freq_readout`

## Requirements
- R1: After reset the block writes five commands with `lcdRs` low, in this order: 0x38, 0x0C, 0x01, 0x06, 0x80. It then goes idle until a strobe is seen.
- R2: For every write, `lcdEn` is high for exactly EN_CYCLES consecutive cycles. `lcdData` and `lcdRs` hold steady for the whole pulse.
- R3: Within a sequence, the low time of `lcdEn` between two writes is exactly LONG_WAIT cycles after the clear command (0x01) and exactly SHORT_WAIT cycles after any other write.
- R4: A refresh starts with command 0x80 (`lcdRs` low). It is followed by the five characters 0x46 0x52 0x45 0x51 0x3D ("FREQ=") with `lcdRs` high.
- R5: Next come the six digits, each written as 0x30 plus the digit value, with `lcdRs` high. Bits [23:20] of `digitsIn` are written first and bits [3:0] last.
- R6: The last digit is followed by 0x48 then 0x7A ("Hz") with `lcdRs` high. After that the block goes idle.
- R7: `lcdDrive` is high during every enable pulse and for one hold cycle after it. At all other times it is low, and `lcdData` reads 0 while `lcdDrive` is low.
- R8: A strobe on `newValue` captures all six digits. If it arrives during a refresh, the refresh in progress finishes with the digits it started with. Exactly one more refresh then follows with the newly captured digits.
- R9: A strobe that arrives during start-up is kept. Its refresh begins one cycle after the start-up sequence ends.
- R10: While reset is asserted, `lcdEn`, `lcdDrive` and `lcdRs` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newValue | input | 1 | One-cycle strobe that captures `digitsIn` |
| digitsIn | input | 24 | Six packed BCD digits, most significant digit in bits [23:20] |
| lcdData | output | 8 | LCD data bus value; zero when not driven |
| lcdRs | output | 1 | Register select: 0 for a command, 1 for a character |
| lcdEn | output | 1 | LCD enable strobe |
| lcdDrive | output | 1 | Output enable for the external data bus tri-state buffer |

## Verification
Every result appears at the outputs some number of cycles after its cause:
- Byte k of a sequence rises on `lcdEn` only after the earlier enable pulses and settling gaps have elapsed.
- A strobe seen while idle raises the first enable of its refresh two cycles later.
- After a start-up strobe, the refresh follows one cycle after the last start-up gap.

The bench does not predict absolute edge times. It samples the pins on the falling clock edge and logs every enable pulse with its byte, register select, high length and the low run before it. Each logged entry is then compared with a value built arithmetically from the requirement. Idle checks wait until a full settling gap has passed after the expected last write, so a late or extra write shows up as a wrong count or a driven bus.

// File: rtl/lcd_freq_pkg.sv
package lcd_freq_pkg;

  localparam int STEP_W = 5;

  // Command bytes
  localparam logic [7:0] CMD_FUNC   = 8'h38;
  localparam logic [7:0] CMD_DISPON = 8'h0C;
  localparam logic [7:0] CMD_CLEAR  = 8'h01;
  localparam logic [7:0] CMD_ENTRY  = 8'h06;
  localparam logic [7:0] CMD_HOME   = 8'h80;

  // Step numbering: start-up commands, then the refresh sequence
  localparam int STEP_LAST_INIT   = 4;
  localparam int STEP_REFRESH     = 5;
  localparam int STEP_FIRST_TEXT  = 6;
  localparam int STEP_FIRST_DIGIT = 11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } seqState_e;

  typedef struct packed {
    logic              snapshot;
    logic [STEP_W-1:0] step;
  } ctlStrobes_t;

endpackage

// File: rtl/lcd_bcd_ascii.sv
module lcd_bcd_ascii (
  input  logic [3:0] bcd,
  output logic [7:0] ascii
);
  assign ascii = 8'h30 + {4'h0, bcd};
endmodule

// File: rtl/lcd_freq_dp.sv
module lcd_freq_dp
  import lcd_freq_pkg::*;
#(
  parameter int DIGITS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  newValue,
  input  logic [4*DIGITS-1:0]   digitsIn,
  input  ctlStrobes_t           ctl,
  output logic [7:0]            curByte,
  output logic                  curRs,
  output logic                  longWait
);
  localparam int NIB_W = 4 * DIGITS;

  logic [NIB_W-1:0]      latched;
  logic [NIB_W-1:0]      shown;
  logic [8*DIGITS-1:0]   asciiFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latched <= '0;
      shown   <= '0;
    end else begin
      if (newValue)     latched <= digitsIn;
      if (ctl.snapshot) shown   <= latched;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    lcd_bcd_ascii conv_i (
      .bcd   (shown[4*g +: 4]),
      .ascii (asciiFlat[8*g +: 8])
    );
  end

  always_comb begin
    curByte = 8'h00;
    unique case (ctl.step)
      STEP_W'(0):                     curByte = CMD_FUNC;
      STEP_W'(1):                     curByte = CMD_DISPON;
      STEP_W'(2):                     curByte = CMD_CLEAR;
      STEP_W'(3):                     curByte = CMD_ENTRY;
      STEP_W'(STEP_LAST_INIT):        curByte = CMD_HOME;
      STEP_W'(STEP_REFRESH):          curByte = CMD_HOME;
      STEP_W'(STEP_FIRST_TEXT):       curByte = 8'h46;
      STEP_W'(STEP_FIRST_TEXT + 1):   curByte = 8'h52;
      STEP_W'(STEP_FIRST_TEXT + 2):   curByte = 8'h45;
      STEP_W'(STEP_FIRST_TEXT + 3):   curByte = 8'h51;
      STEP_W'(STEP_FIRST_TEXT + 4):   curByte = 8'h3D;
      STEP_W'(STEP_FIRST_DIGIT + DIGITS):     curByte = 8'h48;
      STEP_W'(STEP_FIRST_DIGIT + DIGITS + 1): curByte = 8'h7A;
      default: begin
        for (int g = 0; g < DIGITS; g++) begin
          if (ctl.step == STEP_W'(STEP_FIRST_DIGIT + DIGITS - 1 - g))
            curByte = asciiFlat[8*g +: 8];
        end
      end
    endcase
  end

  assign curRs    = (ctl.step >= STEP_W'(STEP_FIRST_TEXT));
  assign longWait = !curRs && (curByte == CMD_CLEAR);

endmodule

// File: rtl/lcd_freq_ctl.sv
module lcd_freq_ctl
  import lcd_freq_pkg::*;
#(
  parameter int DIGITS     = 6,
  parameter int EN_CYCLES  = 12,
  parameter int SHORT_WAIT = 2500,
  parameter int LONG_WAIT  = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        newValue,
  input  logic        longWait,
  output ctlStrobes_t ctl,
  output logic        lcdEn,
  output logic        lcdDrive
);
  localparam int MAX_WAIT  = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CNT_MAX   = (MAX_WAIT > EN_CYCLES) ? MAX_WAIT : EN_CYCLES;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [STEP_W-1:0] LAST_INIT = STEP_W'(STEP_LAST_INIT);
  localparam logic [STEP_W-1:0] FIRST_REF = STEP_W'(STEP_REFRESH);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_FIRST_DIGIT + DIGITS + 1);

  seqState_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  logic              initPending;
  logic              refreshReq;
  logic [CNT_W-1:0]  gapLast;
  logic              startRefresh;

  assign gapLast      = longWait ? CNT_W'(LONG_WAIT - 1) : CNT_W'(SHORT_WAIT - 1);
  assign startRefresh = (st == ST_IDLE) && !initPending && refreshReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      step        <= '0;
      initPending <= 1'b1;
      refreshReq  <= 1'b0;
    end else begin
      refreshReq <= newValue | (refreshReq & ~startRefresh);
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (initPending) begin
            st   <= ST_PULSE;
            step <= '0;
          end else if (refreshReq) begin
            st   <= ST_PULSE;
            step <= FIRST_REF;
          end
        end
        ST_PULSE: begin
          if (cnt == CNT_W'(EN_CYCLES - 1)) begin
            st  <= ST_GAP;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == gapLast) begin
            cnt <= '0;
            if (step == LAST_INIT) begin
              initPending <= 1'b0;
              st          <= ST_IDLE;
            end else if (step == LAST_STEP) begin
              st <= ST_IDLE;
            end else begin
              step <= step + 1'b1;
              st   <= ST_PULSE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign lcdEn        = (st == ST_PULSE);
  assign lcdDrive     = (st == ST_PULSE) || ((st == ST_GAP) && (cnt == '0));
  assign ctl.step     = step;
  assign ctl.snapshot = startRefresh;

endmodule

// File: rtl/lcd_freq_readout.sv
module lcd_freq_readout
  import lcd_freq_pkg::*;
#(
  parameter int DIGITS     = 6,
  parameter int EN_CYCLES  = 12,
  parameter int SHORT_WAIT = 2500,
  parameter int LONG_WAIT  = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                newValue,
  input  logic [4*DIGITS-1:0] digitsIn,
  output logic [7:0]          lcdData,
  output logic                lcdRs,
  output logic                lcdEn,
  output logic                lcdDrive
);
  ctlStrobes_t ctl;
  logic [7:0]  curByte;
  logic        curRs;
  logic        longWait;
  logic        enInt;
  logic        driveInt;

  lcd_freq_ctl #(
    .DIGITS(DIGITS), .EN_CYCLES(EN_CYCLES),
    .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .newValue(newValue), .longWait(longWait),
    .ctl(ctl), .lcdEn(enInt), .lcdDrive(driveInt)
  );

  lcd_freq_dp #(.DIGITS(DIGITS)) dp_i (
    .clk(clk), .rstN(rstN), .newValue(newValue), .digitsIn(digitsIn),
    .ctl(ctl), .curByte(curByte), .curRs(curRs), .longWait(longWait)
  );

  assign lcdData  = driveInt ? curByte : 8'h00;
  assign lcdRs    = driveInt & curRs;
  assign lcdEn    = enInt;
  assign lcdDrive = driveInt;

endmodule

// File: rtl/lcd_freq_readout_chk.sv
module lcd_freq_readout_chk #(
  parameter int DIGITS     = 6,
  parameter int EN_CYCLES  = 12,
  parameter int SHORT_WAIT = 2500,
  parameter int LONG_WAIT  = 100000
) (
  input logic                clk,
  input logic                rstN,
  input logic                newValue,
  input logic [4*DIGITS-1:0] digitsIn,
  input logic [7:0]          lcdData,
  input logic                lcdRs,
  input logic                lcdEn,
  input logic                lcdDrive
);
  logic [31:0] hiRun;
  logic [31:0] loRun;
  logic        seenPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiRun     <= '0;
      loRun     <= '0;
      seenPulse <= 1'b0;
    end else begin
      hiRun     <= lcdEn ? hiRun + 1 : '0;
      loRun     <= lcdEn ? '0 : loRun + 1;
      seenPulse <= seenPulse | lcdEn;
    end
  end

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcdEn) |-> (hiRun == 32'(EN_CYCLES)));

  p_pulse_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lcdEn && $past(lcdEn)) |-> ($stable(lcdData) && $stable(lcdRs)));

  p_gap_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lcdEn) && seenPulse) |-> (loRun >= 32'(SHORT_WAIT)));

  p_drive_covers_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    lcdEn |-> lcdDrive);

  p_bus_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdEn && !$past(lcdEn)) |-> !lcdDrive);

  p_quiet_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lcdDrive |-> (lcdData == 8'h00));

endmodule

bind lcd_freq_readout lcd_freq_readout_chk #(
  .DIGITS(DIGITS), .EN_CYCLES(EN_CYCLES),
  .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)
) chk_i (
  .clk(clk), .rstN(rstN), .newValue(newValue), .digitsIn(digitsIn),
  .lcdData(lcdData), .lcdRs(lcdRs), .lcdEn(lcdEn), .lcdDrive(lcdDrive)
);

// File: tb/lcd_freq_readout_tb.sv
`timescale 1ns/1ps
module lcd_freq_readout_tb_top;
  localparam int EN_C = 3;
  localparam int SHORT_C = 10;
  localparam int LONG_C = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        newValue = 1'b0;
  logic [23:0] digitsIn = '0;
  logic [7:0]  lcdData;
  logic        lcdRs, lcdEn, lcdDrive;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lcd_freq_readout #(.DIGITS(6), .EN_CYCLES(EN_C), .SHORT_WAIT(SHORT_C), .LONG_WAIT(LONG_C)) dut_i (
    .clk(clk), .rstN(rstN), .newValue(newValue), .digitsIn(digitsIn),
    .lcdData(lcdData), .lcdRs(lcdRs), .lcdEn(lcdEn), .lcdDrive(lcdDrive)
  );

  // Pulse log, filled on the falling edge
  logic [7:0] logByte [0:511];
  logic       logRs   [0:511];
  int         logHigh [0:511];
  int         logLow  [0:511];
  logic       logBad  [0:511];
  int  logCount = 0;
  int  lowRun = 0;
  logic prevEn = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (lcdEn) begin
        if (!prevEn) begin
          logByte[logCount] = lcdData;
          logRs[logCount]   = lcdRs;
          logHigh[logCount] = 1;
          logLow[logCount]  = lowRun;
          logBad[logCount]  = !lcdDrive;
          logCount++;
          lowRun = 0;
        end else begin
          logHigh[logCount-1]++;
          if (lcdData != logByte[logCount-1] || lcdRs != logRs[logCount-1] || !lcdDrive)
            logBad[logCount-1] = 1'b1;
        end
      end else begin
        lowRun++;
      end
      prevEn = lcdEn;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] refByte(input int j, input logic [23:0] d);
    case (j)
      0: return 8'h80;
      1: return 8'h46;
      2: return 8'h52;
      3: return 8'h45;
      4: return 8'h51;
      5: return 8'h3D;
      12: return 8'h48;
      13: return 8'h7A;
      default: return 8'h30 + {4'h0, d[23-4*(j-6) -: 4]};
    endcase
  endfunction

  task automatic strobe(input logic [23:0] d);
    @(negedge clk);
    digitsIn = d;
    newValue = 1'b1;
    @(negedge clk);
    newValue = 1'b0;
  endtask

  task automatic waitWrites(input int n);
    while (logCount < n) @(negedge clk);
    repeat (LONG_C + 5) @(negedge clk);
  endtask

  // R2/R3: pulse shape; R4/R5/R6: bytes of one refresh
  task automatic checkRefresh(input int base, input logic [23:0] d, input string tag);
    for (int j = 0; j < 14; j++) begin
      logic [7:0] eb;
      eb = refByte(j, d);
      if (j == 0) check(logByte[base] == eb, {tag, " R4 home cmd"}, logByte[base], eb);
      else if (j < 6) check(logByte[base+j] == eb, {tag, " R4 prefix"}, logByte[base+j], eb);
      else if (j < 12) check(logByte[base+j] == eb, {tag, " R5 digit"}, logByte[base+j], eb);
      else check(logByte[base+j] == eb, {tag, " R6 suffix"}, logByte[base+j], eb);
      check(logRs[base+j] == (j != 0), {tag, " R4 rs"}, logRs[base+j], j != 0);
      check(logHigh[base+j] == EN_C, {tag, " R2 pulse width"}, logHigh[base+j], EN_C);
      check(!logBad[base+j], {tag, " R2 stable/R7 drive"}, logBad[base+j], 0);
      if (j > 0) check(logLow[base+j] == SHORT_C, {tag, " R3 gap"}, logLow[base+j], SHORT_C);
    end
  endtask

  task automatic checkIdle(input string tag);
    check(!lcdDrive && !lcdEn && lcdData == 8'h00, {tag, " R7 bus released"}, {lcdDrive, lcdEn}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] initBytes [0:4];
    int base;
    initBytes[0] = 8'h38; initBytes[1] = 8'h0C; initBytes[2] = 8'h01;
    initBytes[3] = 8'h06; initBytes[4] = 8'h80;

    repeat (3) @(negedge clk);
    check(!lcdEn && !lcdDrive && !lcdRs, "R10 reset outputs", {lcdEn, lcdDrive, lcdRs}, 0);
    rstN = 1'b1;

    // R9: strobe during start-up
    repeat (4) @(negedge clk);
    strobe(24'h907165);
    waitWrites(19);
    check(logCount == 19, "R1/R9 write count", logCount, 19);
    for (int i = 0; i < 5; i++) begin
      check(logByte[i] == initBytes[i], "R1 init byte", logByte[i], initBytes[i]);
      check(logRs[i] == 1'b0, "R1 init rs", logRs[i], 0);
      check(logHigh[i] == EN_C, "R2 init pulse width", logHigh[i], EN_C);
      if (i > 0)
        check(logLow[i] == ((i == 3) ? LONG_C : SHORT_C), "R3 init gap", logLow[i],
              (i == 3) ? LONG_C : SHORT_C);
    end
    check(logLow[5] == SHORT_C + 1, "R9 refresh follows start-up", logLow[5], SHORT_C + 1);
    checkRefresh(5, 24'h907165, "startup");
    checkIdle("after startup");

    // R5: every digit value at every position
    for (int k = 0; k < 10; k++) begin
      logic [23:0] d;
      for (int p = 0; p < 6; p++) d[23-4*p -: 4] = 4'((k + p) % 10);
      base = logCount;
      strobe(d);
      waitWrites(base + 14);
      check(logCount == base + 14, "R8 one refresh per strobe", logCount, base + 14);
      checkRefresh(base, d, "sweep");
      checkIdle("sweep");
    end

    // R8: strobe during a refresh
    base = logCount;
    strobe(24'h123456);
    while (logCount < base + 4) @(negedge clk);
    strobe(24'h987654);
    waitWrites(base + 28);
    check(logCount == base + 28, "R8 exactly one extra refresh", logCount, base + 28);
    checkRefresh(base, 24'h123456, "R8 old value kept");
    checkRefresh(base + 14, 24'h987654, "R8 new value");
    checkIdle("R8 end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule